// File: doc/BRIEF.md
# Dual-Mode 8-bit PWM Timer

This block is an 8-bit counter that produces a pulse-width-modulated waveform on a single output. The counter moves by one step in each clock cycle where the tick enable is high. It has two counting shapes. In sawtooth (fast) mode it counts up to the all-ones value and wraps to zero. In triangle (phase-correct) mode it counts up to the all-ones value and then back down to zero. The counter always runs across the full 8-bit range, so the period cannot be programmed. The pulse width comes from a compare value that software writes. That value is double-buffered, so a new width only takes effect at a point in the period where it cannot cause a glitch.

Each tick is evaluated against the count value present when the tick is accepted. A match between the count and the active compare value sets a compare flag and drives the waveform register according to the output action field. The end of each period sets an overflow flag. Each flag raises its interrupt line when that line is enabled. An acknowledge input clears the flag. The output pin is gated by the action field, so the two disconnected codes hold the pin low.

Top module: `pwm_timer8`

## Requirements
- R1: The mode code selects the counting shape. Code 2'b11 is sawtooth and 2'b10 is triangle. In codes 2'b00 and 2'b01 the counter holds its value, no flag is set and the waveform register holds its level.
- R2: In sawtooth mode each tick advances the count by one, and 0xFF wraps to 0x00. Without a tick the count holds in every mode.
- R3: In triangle mode the count rises to 0xFF on ticks and falls back to 0x00. At 0xFF the next tick gives 0xFE, and at 0x00 while falling the next tick gives 0x01. Switching to sawtooth mode always resumes counting upward.
- R4: When com_i[1] is 0 (codes 00 and reserved 01), pwm_o is 0 and the waveform register is left unchanged. Code 10 clears the waveform on a match. Code 11 sets it on a match.
- R5: In sawtooth mode, a tick at count 0x00 drives the waveform to the opposite of the match level. A match on that same tick takes priority.
- R6: In triangle mode, a match while counting up applies the programmed level. A match while counting down applies the opposite level.
- R7: A write stores into a buffer. In counting modes the buffer moves to the active compare value on a tick at count 0xFF. That is the wrap in sawtooth mode and the peak in triangle mode. In halt modes the active value follows the buffer on the next cycle.
- R8: A tick in a counting mode whose count equals the active compare value sets cmp_flag_o on the following edge.
- R9: ovf_flag_o is set by a tick at 0xFF in sawtooth mode, or by a tick at 0x00 while counting down in triangle mode.
- R10: Each irq output is its flag ANDed with its enable. An acknowledge clears its flag on the next edge, but a set event on that same edge takes priority.
- R11: With a tick every cycle and a compare value N in 1..254, the output is high for N cycles out of 256 in sawtooth mode with code 10. In triangle mode with code 10 it is high for 2N cycles out of 510.
- R12: After reset, the count, the compare buffer, the active compare value, the waveform register and both flags are 0. The direction is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Step enable for the counter |
| mode_i | input | 2 | Counting mode code |
| com_i | input | 2 | Output action on compare match |
| ocr_wr_i | input | 1 | Write strobe for the compare buffer |
| ocr_data_i | input | 8 | Compare value to write |
| cmp_ie_i | input | 1 | Compare interrupt enable |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cmp_ack_i | input | 1 | Compare interrupt acknowledge |
| ovf_ack_i | input | 1 | Overflow interrupt acknowledge |
| cnt_o | output | 8 | Current count |
| pwm_o | output | 1 | Waveform output |
| cmp_flag_o | output | 1 | Compare-match flag |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_irq_o | output | 1 | Compare interrupt request |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
A wrong direction bit shows up on cnt_o at the first tick after the peak or the floor of the triangle, because the count then moves the wrong way. A wrong active compare value stays hidden until the next tick at the programmed match point. At that tick pwm_o and cmp_flag_o differ from the model one cycle later. A buffer load at the wrong point shows up only after a write, within one period, as a pulse width of the wrong length. The duty-cycle windows and the cycle-by-cycle comparison both catch this.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    MODE_HALT     = 2'b00,
    MODE_HALT_ALT = 2'b01,
    MODE_TRI      = 2'b10,
    MODE_SAW      = 2'b11
  } mode_e;

  localparam int unsigned N_FLAGS  = 2;
  localparam int unsigned FLAG_CMP = 0;
  localparam int unsigned FLAG_OVF = 1;
endpackage

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
  import pwm_timer_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  mode_e            mode_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             up_o,
  output logic             run_o,
  output logic             saw_o
);
  localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic             up_q;

  assign saw_o = (mode_i == MODE_SAW);
  assign run_o = tick_i & ((mode_i == MODE_SAW) | (mode_i == MODE_TRI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (run_o) begin
      if (saw_o) begin
        cnt_q <= cnt_q + ONE;
        up_q  <= 1'b1;
      end else if (up_q) begin
        if (cnt_q == MAX) begin
          cnt_q <= MAX - ONE;
          up_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_q <= ONE;
          up_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
endmodule

// File: rtl/pwm_tmr_compare.sv
module pwm_tmr_compare #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             saw_i,
  input  logic             up_i,
  input  logic             halt_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [1:0]       com_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] ocr_act_o,
  output logic             match_o,
  output logic             wave_o
);
  localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] buf_q, act_q;
  logic             wave_q;
  logic             load;
  logic             hit_lvl;

  // shadow loads at the peak/wrap so a period never sees two compare values
  assign load    = halt_i | (run_i & (cnt_i == MAX));
  assign match_o = run_i & (cnt_i == act_q);
  assign hit_lvl = (saw_i | up_i) ? com_i[0] : ~com_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) buf_q <= data_i;
      if (load) act_q <= buf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else if (com_i[1]) begin
      if (match_o)                            wave_q <= hit_lvl;
      else if (run_i && saw_i && cnt_i == '0) wave_q <= ~com_i[0];
    end
  end

  assign ocr_act_o = act_q;
  assign wave_o    = wave_q;
endmodule

// File: rtl/pwm_tmr_flag.sv
module pwm_tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~ack_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       com_i,
  input  logic             ocr_wr_i,
  input  logic [WIDTH-1:0] ocr_data_i,
  input  logic             cmp_ie_i,
  input  logic             ovf_ie_i,
  input  logic             cmp_ack_i,
  input  logic             ovf_ack_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             pwm_o,
  output logic             cmp_flag_o,
  output logic             ovf_flag_o,
  output logic             cmp_irq_o,
  output logic             ovf_irq_o
);
  localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};

  mode_e            mode;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] ocr_act;
  logic             up, run, saw, match, wave, ovf_ev;
  logic [N_FLAGS-1:0] f_set, f_ack, f_ie, f_flag, f_irq;

  assign mode = mode_e'(mode_i);

  pwm_tmr_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .mode_i (mode),
    .cnt_o  (cnt),
    .up_o   (up),
    .run_o  (run),
    .saw_o  (saw)
  );

  pwm_tmr_compare #(.WIDTH(WIDTH)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .saw_i     (saw),
    .up_i      (up),
    .halt_i    (~mode_i[1]),
    .cnt_i     (cnt),
    .com_i     (com_i),
    .wr_i      (ocr_wr_i),
    .data_i    (ocr_data_i),
    .ocr_act_o (ocr_act),
    .match_o   (match),
    .wave_o    (wave)
  );

  // period end: wrap in sawtooth, floor of the down slope in triangle
  assign ovf_ev = run & (saw ? (cnt == MAX) : (~up & (cnt == '0)));

  assign f_set[FLAG_CMP] = match;
  assign f_set[FLAG_OVF] = ovf_ev;
  assign f_ack[FLAG_CMP] = cmp_ack_i;
  assign f_ack[FLAG_OVF] = ovf_ack_i;
  assign f_ie[FLAG_CMP]  = cmp_ie_i;
  assign f_ie[FLAG_OVF]  = ovf_ie_i;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    pwm_tmr_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (f_set[g]),
      .ack_i  (f_ack[g]),
      .ie_i   (f_ie[g]),
      .flag_o (f_flag[g]),
      .irq_o  (f_irq[g])
    );
  end

  assign cnt_o      = cnt;
  assign pwm_o      = com_i[1] & wave;
  assign cmp_flag_o = f_flag[FLAG_CMP];
  assign ovf_flag_o = f_flag[FLAG_OVF];
  assign cmp_irq_o  = f_irq[FLAG_CMP];
  assign ovf_irq_o  = f_irq[FLAG_OVF];
endmodule

// File: rtl/pwm_timer8_checker.sv
module pwm_timer8_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [1:0]       mode_i,
  input logic             cmp_ack_i,
  input logic [WIDTH-1:0] cnt_o,
  input logic [WIDTH-1:0] ocr_act_i,
  input logic             cmp_flag_o,
  input logic             ovf_flag_o
);
  localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  a_r2_saw_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 2'b11) |=> cnt_o == WIDTH'($past(cnt_o) + ONE));

  a_r2_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));

  a_r1_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |=> $stable(cnt_o));

  a_r3_turn_at_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 2'b10 && cnt_o == MAX) |=> cnt_o == MAX - ONE);

  a_r9_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == 2'b11 && cnt_o == MAX) |=> ovf_flag_o);

  a_r8_match_sets_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i[1] && cnt_o == ocr_act_i) |=> cmp_flag_o);

  a_r7_shadow_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && !(tick_i && cnt_o == MAX)) |=> $stable(ocr_act_i));

  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_ack_i && !(tick_i && mode_i[1] && cnt_o == ocr_act_i)) |=> !cmp_flag_o);
endmodule

bind pwm_timer8 pwm_timer8_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .mode_i     (mode_i),
  .cmp_ack_i  (cmp_ack_i),
  .cnt_o      (cnt_o),
  .ocr_act_i  (ocr_act),
  .cmp_flag_o (cmp_flag_o),
  .ovf_flag_o (ovf_flag_o)
);

// File: tb/pwm_timer8_bench.sv
`timescale 1ns/1ps
module pwm_timer8_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [1:0] com_i = 2'b00;
  logic       ocr_wr_i = 1'b0;
  logic [7:0] ocr_data_i = 8'h00;
  logic       cmp_ie_i = 1'b0, ovf_ie_i = 1'b0, cmp_ack_i = 1'b0, ovf_ack_i = 1'b0;
  logic [7:0] cnt_o;
  logic       pwm_o, cmp_flag_o, ovf_flag_o, cmp_irq_o, ovf_irq_o;

  int n_cmp = 0, n_bad = 0;

  // reference state
  logic [7:0] m_cnt = 0, m_buf = 0, m_act = 0;
  logic       m_up = 1, m_wave = 0, m_cf = 0, m_of = 0;

  always #2.5 clk_i = ~clk_i;

  pwm_timer8 u_pwm_timer8 (.*);

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_pwm();
    return com_i[1] & m_wave;
  endfunction

  // expected next state from the requirements, for the inputs now applied
  task automatic model_step();
    logic run, saw, match, ovf, load;
    run   = tick_i & mode_i[1];
    saw   = (mode_i == 2'b11);
    match = run && (m_cnt == m_act);
    ovf   = run && (saw ? (m_cnt == 8'hFF) : (!m_up && m_cnt == 8'h00));
    load  = !mode_i[1] || (run && m_cnt == 8'hFF);
    if (com_i[1]) begin
      if (match) m_wave = (saw || m_up) ? com_i[0] : ~com_i[0];        // R5 R6
      else if (run && saw && m_cnt == 8'h00) m_wave = ~com_i[0];       // R5
    end
    m_cf = match | (m_cf & ~cmp_ack_i);                                  // R8 R10
    m_of = ovf   | (m_of & ~ovf_ack_i);                                  // R9 R10
    if (load) m_act = m_buf;                                             // R7
    if (ocr_wr_i) m_buf = ocr_data_i;
    if (run) begin
      if (saw) begin m_cnt = m_cnt + 8'd1; m_up = 1'b1; end              // R2
      else if (m_up) begin
        if (m_cnt == 8'hFF) begin m_cnt = 8'hFE; m_up = 1'b0; end        // R3
        else m_cnt = m_cnt + 8'd1;
      end else begin
        if (m_cnt == 8'h00) begin m_cnt = 8'h01; m_up = 1'b1; end
        else m_cnt = m_cnt - 8'd1;
      end
    end
  endtask

  task automatic compare_all();
    check(mode_i == 2'b10 ? "R3 count" : (mode_i == 2'b11 ? "R2 count" : "R1 count"),
          cnt_o, m_cnt);
    check(com_i[1] ? (mode_i == 2'b10 ? "R6 pwm" : "R5 pwm") : "R4 pwm", pwm_o, exp_pwm());
    check("R8 cmp_flag", cmp_flag_o, m_cf);
    check("R9 ovf_flag", ovf_flag_o, m_of);
    check("R10 cmp_irq", cmp_irq_o, m_cf & cmp_ie_i);
    check("R10 ovf_irq", ovf_irq_o, m_of & ovf_ie_i);
  endtask

  // one cycle: compare at the falling edge, then apply new inputs
  task automatic cycle(input logic tk, input logic [1:0] md, input logic [1:0] cm,
                       input logic wr, input logic [7:0] d,
                       input logic ca, input logic oa);
    @(negedge clk_i);
    compare_all();
    tick_i = tk; mode_i = md; com_i = cm; ocr_wr_i = wr; ocr_data_i = d;
    cmp_ack_i = ca; ovf_ack_i = oa;
    model_step();
  endtask

  task automatic duty(input logic [1:0] md, input logic [7:0] n,
                      input int settle, input int win, input int exp, input string req);
    int hi;
    cycle(1'b1, md, 2'b10, 1'b1, n, 1'b0, 1'b0);
    for (int i = 0; i < settle; i++) cycle(1'b1, md, 2'b10, 1'b0, 8'h00, 1'b1, 1'b1);
    hi = 0;
    for (int i = 0; i < win; i++) begin
      cycle(1'b1, md, 2'b10, 1'b0, 8'h00, 1'b1, 1'b1);
      hi += int'(pwm_o);
    end
    check(req, hi, exp);
  endtask

  initial begin
    #(200000 * 5.0);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #12 rst_ni = 1'b1;
    // R12 reset state
    @(negedge clk_i);
    check("R12 cnt", cnt_o, 0);
    check("R12 pwm", pwm_o, 0);
    check("R12 flags", {cmp_flag_o, ovf_flag_o}, 0);

    // R1 halt modes hold the count even with ticks
    for (int i = 0; i < 20; i++) cycle(1'b1, 2'b01, 2'b11, 1'b0, 8'h00, 1'b0, 1'b0);
    // R2 sawtooth through a wrap, without and with gaps
    for (int i = 0; i < 300; i++) cycle(1'b1, 2'b11, 2'b11, i == 0, 8'h10, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) cycle(i % 3 != 0, 2'b11, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0);
    // R3 triangle through peak and floor
    for (int i = 0; i < 600; i++) cycle(1'b1, 2'b10, 2'b11, 1'b0, 8'h00, i % 50 == 0, 1'b0);

    // R11 duty in both shapes
    duty(2'b11, 8'h40, 600, 256, 64, "R11 saw duty");
    duty(2'b11, 8'hC8, 600, 256, 200, "R11 saw duty");
    duty(2'b10, 8'h40, 1100, 510, 128, "R11 tri duty");
    duty(2'b10, 8'h05, 1100, 510, 10, "R11 tri duty");

    // R7 extremes of compare value, plus R10 enables
    cmp_ie_i = 1'b1; ovf_ie_i = 1'b1;
    for (int i = 0; i < 600; i++) cycle(1'b1, 2'b11, 2'b10, i == 0, 8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 600; i++) cycle(1'b1, 2'b10, 2'b11, i == 0, 8'hFF, 1'b0, i % 7 == 0);

    // random mix
    begin
      logic [1:0] md, cm;
      md = 2'b11; cm = 2'b10;
      for (int i = 0; i < 30000; i++) begin
        logic [7:0] d;
        if ($urandom_range(0, 499) == 0) md = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 199) == 0) cm = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 99) == 0) cmp_ie_i = ~cmp_ie_i;
        if ($urandom_range(0, 99) == 0) ovf_ie_i = ~ovf_ie_i;
        case ($urandom_range(0, 3))
          0: d = 8'h00;
          1: d = 8'hFF;
          default: d = 8'($urandom);
        endcase
        cycle($urandom_range(0, 3) != 0, md, cm, $urandom_range(0, 39) == 0, d,
              $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
      end
    end
    @(negedge clk_i);
    compare_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule